// File: doc/BRIEF.md
# Four-Channel DMA Request Checker and Count Keeper

This block keeps the programming state for a small set of DMA channels. Each channel has four 32-bit words: a general-purpose scratch word, a control word, a remaining byte count and a start address. A device asks for service on one channel. It gives a direction and the number of bytes it wants. The block checks the request against the channel's control word. If the request is legal, it clips the length to the remaining count and presents the address and the clipped length to a downstream address translator. When the translator reports completion, the block lowers the count and records a terminal-count flag.

A request that cannot be served does not start a transfer. This happens when the channel is off, or when the device's direction disagrees with the programmed direction. In that case the block sets a memory-error flag in the channel's control word and sets the channel's bit in a sticky error-source register. That register is also driven out as a vector for a non-maskable interrupt line.

Software reaches every word over a simple 32-bit register port. The port does full-word writes, and it does byte and halfword writes that merge into the addressed word.

Top module: `dmac_chan_ctrl`

## Requirements
- R1: After reset, every channel word and the error-source register read as zero, reqReady is 1 and xferValid is 0.
- R2: Channel n, word k (k = 0 scratch, 1 control, 2 count, 3 address) sits at byte offset 0x100 + 32·n + 8·k. The error-source register reads at 0x200 and ignores writes. Any other offset, including offsets with bit 2 set inside a channel window, reads 0 and ignores writes. A read returns the whole aligned word.
- R3: regSize 0 writes regWdata[7:0] into byte lane regAddr[1:0]. regSize 1 writes regWdata[15:0] into halfword lane regAddr[1]. Sizes 2 and 3 write the full word. The lanes that are not written keep their value.
- R4: The control word uses these bits: bit 0 is enable, bit 1 is memory-to-device (clear means device-to-memory), bit 8 is terminal count, bit 9 is memory error and bit 10 is address error. An accepted request clears bits 8, 9 and 10 of its channel's control word.
- R5: An accepted request is refused when bit 0 is clear or reqToDev differs from bit 1. A refused request sets bit 9 and bit n of the error-source register, which stays set until reset. It starts no transfer, and reqReady stays 1.
- R6: A legal request raises xferValid on the next cycle. xferAddr is the channel's address word, xferCh is the channel, and xferLen is the smaller of reqLen and the count word. These stay steady until xferDone.
- R7: xferDone while xferValid is high subtracts xferLen from the count, sets control bit 8 and leaves the address word unchanged. xferValid then drops and reqReady returns on the next cycle.
- R8: While a transfer is outstanding, reqReady is 0 and requests change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regSize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| regWdata | input | 32 | Write data, low-aligned for narrow writes |
| regRdata | output | 32 | Combinational read data for regAddr |
| reqValid | input | 1 | Device service request |
| reqReady | output | 1 | Request accepted this cycle when high |
| reqCh | input | CH_W | Requesting channel |
| reqToDev | input | 1 | 1 = memory to device, 0 = device to memory |
| reqLen | input | 32 | Requested byte count |
| xferValid | output | 1 | Transfer handed to the translator |
| xferCh | output | CH_W | Channel of the outstanding transfer |
| xferAddr | output | 32 | Start address of the transfer |
| xferLen | output | 32 | Clipped byte count |
| xferDone | input | 1 | Translator finished the transfer |
| nmiSrc | output | NUM_CH | Sticky per-channel error sources |

## Verification
The bench builds the block with the default four channels and a 10-bit register offset. With these values every channel window is reachable, and so are the unmapped gap from 0x180 to 0x1FF and the error-source word at 0x200. The highest-numbered channel is exercised as well, so the top error-source bit gets set. A 32-bit count allows clipping in both directions and a zero-count transfer.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int DW = 32;
  localparam int WORDS_PER_CH = 4;
  localparam int CH_STRIDE = 32;
  localparam int CH_BASE = 'h100;
  localparam int ERRSRC_OFF = 'h200;

  localparam int BIT_EN = 0;
  localparam int BIT_TODEV = 1;
  localparam int BIT_TC = 8;
  localparam int BIT_MEMERR = 9;
  localparam int BIT_ADDRERR = 10;

  localparam logic [DW-1:0] FLAG_MASK =
    (DW'(1) << BIT_TC) | (DW'(1) << BIT_MEMERR) | (DW'(1) << BIT_ADDRERR);

  typedef enum logic [1:0] {W_SCRATCH = 2'd0, W_CTRL = 2'd1, W_COUNT = 2'd2, W_ADDR = 2'd3} word_e;

  typedef struct packed {
    logic clrFlags;
    logic setErr;
    logic finish;
    logic [DW-1:0] len;
  } dmac_stb_t;
endpackage

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 10,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic                       regWrEn,
  input  logic [1:0]                 regSize,
  input  logic [DW-1:0]              regWdata,
  output logic [DW-1:0]              regRdata,
  input  dmac_stb_t                  stb,
  input  logic [CH_W-1:0]            stbCh,
  output logic [NUM_CH-1:0][DW-1:0]  ctrlArr,
  output logic [NUM_CH-1:0][DW-1:0]  countArr,
  output logic [NUM_CH-1:0][DW-1:0]  addrArr,
  output logic [NUM_CH-1:0]          nmiSrc
);
  localparam int CH_END = CH_BASE + NUM_CH * CH_STRIDE;

  logic [31:0] addrExt, offs;
  logic chHit, errHit;
  logic [CH_W-1:0] hitCh;
  logic [1:0] hitWord;
  logic [NUM_CH-1:0][WORDS_PER_CH-1:0][DW-1:0] allWords;
  logic [DW-1:0] oldWord, laneMask, laneData, mergedWord;
  logic [4:0] shAmt;

  assign addrExt = 32'(regAddr);
  assign offs    = addrExt - 32'(CH_BASE);
  assign chHit   = (addrExt >= 32'(CH_BASE)) && (addrExt < 32'(CH_END)) && !addrExt[2];
  assign errHit  = (addrExt & ~32'h3) == 32'(ERRSRC_OFF);
  assign hitCh   = offs[5 +: CH_W];
  assign hitWord = offs[4:3];
  assign oldWord = chHit ? allWords[hitCh][hitWord] : '0;

  always_comb begin
    if (chHit)       regRdata = oldWord;
    else if (errHit) regRdata = DW'(nmiSrc);
    else             regRdata = '0;
  end

  always_comb begin
    shAmt = '0;
    laneMask = '1;
    case (regSize)
      2'd0: begin shAmt = {regAddr[1:0], 3'b000}; laneMask = DW'(8'hFF) << shAmt; end
      2'd1: begin shAmt = {regAddr[1], 4'b0000}; laneMask = DW'(16'hFFFF) << shAmt; end
      default: laneMask = '1;
    endcase
    laneData   = regWdata << shAmt;
    mergedWord = (oldWord & ~laneMask) | (laneData & laneMask);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WORDS_PER_CH-1:0][DW-1:0] words;
    logic selC, engCtrl, engCount, busSel;
    assign selC     = (stbCh == CH_W'(c));
    assign engCtrl  = selC && (stb.clrFlags || stb.finish);
    assign engCount = selC && stb.finish;
    assign busSel   = regWrEn && chHit && (hitCh == CH_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        words <= '0;
      end else begin
        for (int k = 0; k < WORDS_PER_CH; k++) begin
          if (busSel && hitWord == 2'(k) &&
              !((k == int'(W_CTRL) && engCtrl) || (k == int'(W_COUNT) && engCount)))
            words[k] <= mergedWord;
        end
        if (selC && stb.clrFlags)
          words[W_CTRL] <= (words[W_CTRL] & ~FLAG_MASK) |
                           (stb.setErr ? (DW'(1) << BIT_MEMERR) : '0);
        if (selC && stb.finish) begin
          words[W_CTRL]  <= words[W_CTRL] | (DW'(1) << BIT_TC);
          words[W_COUNT] <= words[W_COUNT] - stb.len;
        end
      end
    end

    assign allWords[c] = words;
    assign ctrlArr[c]  = words[W_CTRL];
    assign countArr[c] = words[W_COUNT];
    assign addrArr[c]  = words[W_ADDR];
  end

  always_ff @(posedge clk) begin
    if (rst) nmiSrc <= '0;
    else if (stb.clrFlags && stb.setErr) nmiSrc[stbCh] <= 1'b1;
  end
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reqValid,
  input  logic [CH_W-1:0]            reqCh,
  input  logic                       reqToDev,
  input  logic [DW-1:0]              reqLen,
  output logic                       reqReady,
  input  logic                       xferDone,
  output logic                       xferValid,
  output logic [CH_W-1:0]            xferCh,
  output logic [DW-1:0]              xferAddr,
  output logic [DW-1:0]              xferLen,
  input  logic [NUM_CH-1:0][DW-1:0]  ctrlArr,
  input  logic [NUM_CH-1:0][DW-1:0]  countArr,
  input  logic [NUM_CH-1:0][DW-1:0]  addrArr,
  output dmac_stb_t                  stb,
  output logic [CH_W-1:0]            stbCh
);
  logic busy, accept, legal;
  logic [DW-1:0] selCtrl, selCount, clipLen;

  assign selCtrl  = ctrlArr[reqCh];
  assign selCount = countArr[reqCh];
  assign accept   = reqValid && !busy;
  assign legal    = selCtrl[BIT_EN] && (selCtrl[BIT_TODEV] == reqToDev);
  assign clipLen  = (reqLen < selCount) ? reqLen : selCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      xferCh <= '0;
      xferAddr <= '0;
      xferLen <= '0;
    end else if (busy) begin
      if (xferDone) busy <= 1'b0;
    end else if (accept && legal) begin
      busy <= 1'b1;
      xferCh <= reqCh;
      xferAddr <= addrArr[reqCh];
      xferLen <= clipLen;
    end
  end

  assign reqReady     = !busy;
  assign xferValid    = busy;
  assign stbCh        = busy ? xferCh : reqCh;
  assign stb.clrFlags = accept;
  assign stb.setErr   = accept && !legal;
  assign stb.finish   = busy && xferDone;
  assign stb.len      = xferLen;
endmodule

// File: rtl/dmac_chan_ctrl.sv
module dmac_chan_ctrl
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 10,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [1:0]        regSize,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [CH_W-1:0]   reqCh,
  input  logic              reqToDev,
  input  logic [31:0]       reqLen,
  output logic              xferValid,
  output logic [CH_W-1:0]   xferCh,
  output logic [31:0]       xferAddr,
  output logic [31:0]       xferLen,
  input  logic              xferDone,
  output logic [NUM_CH-1:0] nmiSrc
);
  dmac_stb_t stb;
  logic [CH_W-1:0] stbCh;
  logic [NUM_CH-1:0][DW-1:0] ctrlArr, countArr, addrArr;

  dmac_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqCh(reqCh), .reqToDev(reqToDev),
    .reqLen(reqLen), .reqReady(reqReady), .xferDone(xferDone), .xferValid(xferValid),
    .xferCh(xferCh), .xferAddr(xferAddr), .xferLen(xferLen), .ctrlArr(ctrlArr),
    .countArr(countArr), .addrArr(addrArr), .stb(stb), .stbCh(stbCh)
  );

  dmac_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn), .regSize(regSize),
    .regWdata(regWdata), .regRdata(regRdata), .stb(stb), .stbCh(stbCh),
    .ctrlArr(ctrlArr), .countArr(countArr), .addrArr(addrArr), .nmiSrc(nmiSrc)
  );
endmodule

// File: rtl/dmac_chan_ctrl_chk.sv
module dmac_chan_ctrl_chk #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic [31:0]       reqLen,
  input logic              xferValid,
  input logic [CH_W-1:0]   xferCh,
  input logic [31:0]       xferAddr,
  input logic [31:0]       xferLen,
  input logic              xferDone,
  input logic [NUM_CH-1:0] nmiSrc
);
  AST_ERRSRC_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((nmiSrc & $past(nmiSrc)) == $past(nmiSrc))); // R5
  AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (rst)
    (nmiSrc != $past(nmiSrc)) |-> !xferValid); // R5
  AST_LEN_CLIPPED: assert property (@(posedge clk) disable iff (rst)
    $rose(xferValid) |-> (xferLen <= $past(reqLen))); // R6
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (xferValid && !xferDone) |=> (xferValid && $stable(xferAddr) && $stable(xferLen) && $stable(xferCh))); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (xferValid && xferDone) |=> (reqReady && !xferValid)); // R7
endmodule

bind dmac_chan_ctrl dmac_chan_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst(rst), .reqReady(reqReady), .reqLen(reqLen), .xferValid(xferValid),
  .xferCh(xferCh), .xferAddr(xferAddr), .xferLen(xferLen), .xferDone(xferDone),
  .nmiSrc(nmiSrc)
);

// File: tb/dmac_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dmac_chan_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int AW = 10;

  logic clk = 0, rst = 1;
  logic [AW-1:0] regAddr = '0;
  logic regWrEn = 0;
  logic [1:0] regSize = 2'd2;
  logic [31:0] regWdata = '0, regRdata;
  logic reqValid = 0, reqReady, reqToDev = 0, xferValid, xferDone = 0;
  logic [1:0] reqCh = '0, xferCh;
  logic [31:0] reqLen = '0, xferAddr, xferLen;
  logic [NCH-1:0] nmiSrc;

  int tests = 0, fails = 0;
  bit finished = 0;

  // behavioural model
  logic [31:0] m [NCH][4];
  logic [NCH-1:0] mNmi;
  bit mBusy;
  int mCh;
  logic [31:0] mAddr, mLen;

  always #2.5 clk = ~clk;

  dmac_chan_ctrl #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn), .regSize(regSize),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid), .reqReady(reqReady),
    .reqCh(reqCh), .reqToDev(reqToDev), .reqLen(reqLen), .xferValid(xferValid),
    .xferCh(xferCh), .xferAddr(xferAddr), .xferLen(xferLen), .xferDone(xferDone),
    .nmiSrc(nmiSrc)
  );

  function automatic logic [31:0] mRead(int a);
    if (a >= 'h100 && a < 'h100 + 32 * NCH && (a & 4) == 0)
      return m[(a - 'h100) / 32][(a / 8) % 4];
    if ((a & ~3) == 'h200) return 32'(mNmi);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) for (int k = 0; k < 4; k++) m[c][k] = '0;
      mNmi = '0; mBusy = 0; mCh = 0; mAddr = '0; mLen = '0;
    end else begin
      int tc; bit tCtrl, tCnt;
      tc = 0; tCtrl = 0; tCnt = 0;
      if (mBusy && xferDone) begin
        m[mCh][1] = m[mCh][1] | 32'h100;
        m[mCh][2] = m[mCh][2] - mLen;
        mBusy = 0; tc = mCh; tCtrl = 1; tCnt = 1;
      end else if (!mBusy && reqValid) begin
        logic [31:0] cw;
        tc = int'(reqCh); tCtrl = 1;
        cw = m[tc][1];
        if (!cw[0] || cw[1] != reqToDev) begin
          m[tc][1] = (cw & ~32'h700) | 32'h200;
          mNmi[tc] = 1'b1;
        end else begin
          m[tc][1] = cw & ~32'h700;
          mBusy = 1; mCh = tc; mAddr = m[tc][3];
          mLen = (reqLen < m[tc][2]) ? reqLen : m[tc][2];
        end
      end
      if (regWrEn) begin
        int a; a = int'(regAddr);
        if (a >= 'h100 && a < 'h100 + 32 * NCH && (a & 4) == 0) begin
          int c, k; logic [31:0] old, mask, dat; int sh;
          c = (a - 'h100) / 32; k = (a / 8) % 4;
          if (!(c == tc && ((k == 1 && tCtrl) || (k == 2 && tCnt)))) begin
            old = m[c][k];
            if (regSize == 0) begin sh = 8 * (a % 4); mask = 32'hFF << sh; end
            else if (regSize == 1) begin sh = 16 * ((a / 2) % 2); mask = 32'hFFFF << sh; end
            else begin sh = 0; mask = 32'hFFFFFFFF; end
            dat = regWdata << sh;
            m[c][k] = (old & ~mask) | (dat & mask);
          end
        end
      end
    end
  end

  // per-clock comparison of port behaviour (R6 R8)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      tests++;
      if (reqReady !== !mBusy || xferValid !== mBusy || nmiSrc !== mNmi ||
          (mBusy && (xferAddr !== mAddr || xferLen !== mLen || int'(xferCh) != mCh))) begin
        fails++;
        $display("FAIL R6 R8 per-clock: rdy=%0b val=%0b addr=%h len=%0d ch=%0d nmi=%b exp rdy=%0b val=%0b addr=%h len=%0d ch=%0d nmi=%b",
                 reqReady, xferValid, xferAddr, xferLen, xferCh, nmiSrc,
                 !mBusy, mBusy, mAddr, mLen, mCh, mNmi);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk);
    regAddr = AW'(a);
    #1;
    chk(tag, regRdata, mRead(a));
  endtask

  task automatic wr(int a, int sz, logic [31:0] d);
    @(negedge clk);
    regAddr = AW'(a); regSize = 2'(sz); regWdata = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic req(int ch, bit toDev, logic [31:0] len);
    @(negedge clk);
    reqValid = 1; reqCh = 2'(ch); reqToDev = toDev; reqLen = len;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic finishXfer(int waitCycles);
    for (int i = 0; i < waitCycles; i++) @(negedge clk);
    xferDone = 1;
    @(negedge clk);
    xferDone = 0;
  endtask

  function automatic int ca(int ch, int k);
    return 'h100 + 32 * ch + 8 * k;
  endfunction

  task automatic report();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    chk("R1 reqReady", 32'(reqReady), 32'd1);
    chk("R1 xferValid", 32'(xferValid), 32'd0);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 4; k++) begin
        rd(ca(c, k), "R1 word");
        chk("R1 word zero", regRdata, 32'h0);
      end
    rd('h200, "R1 errsrc");

    // R2 layout
    wr(ca(0, 0), 2, 32'hA5A5_5A5A);
    wr(ca(0, 2), 2, 32'd100);
    wr(ca(0, 3), 2, 32'h0000_1000);
    wr(ca(0, 1), 2, 32'h0000_0701);
    wr(ca(3, 3), 2, 32'hCAFE_0000);
    for (int k = 0; k < 4; k++) rd(ca(0, k), "R2 ch0 word");
    rd(ca(3, 3), "R2 ch3 addr");
    chk("R2 ch3 addr value", regRdata, 32'hCAFE_0000);
    wr('h104, 2, 32'hFFFF_FFFF);
    rd('h104, "R2 bit2 hole");
    chk("R2 bit2 hole zero", regRdata, 32'h0);
    wr('h180, 2, 32'h1234_5678);
    rd('h180, "R2 unmapped");
    wr('h200, 2, 32'hF);
    rd('h200, "R2 errsrc ro");
    chk("R2 errsrc ro zero", regRdata, 32'h0);
    rd(ca(0, 0) + 4, "R2 hole keeps ch0");

    // R3 narrow merges
    wr(ca(1, 3), 2, 32'h1122_3344);
    wr(ca(1, 3) + 2, 0, 32'hFFFF_FFAB);
    rd(ca(1, 3), "R3 byte lane2");
    chk("R3 byte lane2 value", regRdata, 32'h11AB_3344);
    wr(ca(1, 3) + 2, 1, 32'h0000_BEEF);
    rd(ca(1, 3), "R3 half upper");
    chk("R3 half upper value", regRdata, 32'hBEEF_3344);
    wr(ca(1, 3) + 3, 0, 32'h0000_0077);
    rd(ca(1, 3), "R3 byte lane3");
    wr(ca(1, 3), 1, 32'h0000_0102);
    rd(ca(1, 3), "R3 half lower");

    // R4 R6 R7 legal transfer, R8 requests ignored while busy
    req(0, 0, 32'd40);
    rd(ca(0, 1), "R4 flags cleared");
    chk("R4 flags cleared value", regRdata, 32'h0000_0001);
    @(negedge clk);
    reqValid = 1; reqCh = 2'd2; reqToDev = 0; reqLen = 32'd5;
    repeat (3) @(negedge clk);
    reqValid = 0;
    rd(ca(2, 1), "R8 ignored ch2 ctrl");
    rd('h200, "R8 no errsrc");
    finishXfer(0);
    rd(ca(0, 2), "R7 count");
    chk("R7 count value", regRdata, 32'd60);
    rd(ca(0, 1), "R7 tc set");
    chk("R7 tc value", regRdata, 32'h0000_0101);
    rd(ca(0, 3), "R7 addr kept");

    // R6 clip to count, then zero count
    req(0, 0, 32'd500);
    finishXfer(2);
    rd(ca(0, 2), "R6 clipped to zero");
    chk("R6 clipped value", regRdata, 32'd0);
    req(0, 0, 32'd8);
    finishXfer(1);
    rd(ca(0, 2), "R6 zero count");

    // R5 refusals
    req(2, 0, 32'd4);
    rd(ca(2, 1), "R5 disabled memerr");
    chk("R5 disabled memerr value", regRdata, 32'h0000_0200);
    wr(ca(3, 1), 2, 32'h0000_0003);
    wr(ca(3, 2), 2, 32'd16);
    req(3, 0, 32'd4);
    rd('h200, "R5 errsrc two bits");
    chk("R5 errsrc value", regRdata, 32'h0000_000C);
    rd(ca(3, 2), "R5 count untouched");
    req(3, 1, 32'd4);
    rd(ca(3, 1), "R4 memerr cleared");
    finishXfer(1);
    rd(ca(3, 2), "R7 ch3 count");
    rd('h200, "R5 errsrc sticky");
    repeat (2) @(negedge clk);
    report();
  end
endmodule